// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Front End

This block sits between an external parallel host bus and the register and RAM core of a small timekeeping and storage device. The core holds a 128-location space: clock and control registers plus 114 bytes of general storage. The host first presents an address on a multiplexed address/data bus and marks it with an address-latch strobe. It then moves one byte in a data phase. The block converts that asynchronous bus activity into single-cycle read and write pulses in the core clock domain, each with a stable address. It also steers the tristate enable of the data bus.

A pin-strapped style input picks how two control pins are read. With the style input high, one pin is a data strobe and the other is a direction level (high for read, low for write). Write data is taken on the strobe's falling edge, and read data is driven only after its rising edge. With the style input low, the same two pins are separate active-low strobes: the first one drives read data while it is low, and the rising edge of the second one takes the write data. An active-low chip select and an active-low lockout input gate every access. All bus pins pass through a two-stage synchronizer before they are decoded.

Top module: `hbi_host_bus`

## Requirements
- R1: With `bus_style` = 1, a strobe pulse while `bus_dir` = 1 is a read: it raises `core_rd` and never `core_wr`.
- R2: With `bus_style` = 1, each falling edge of `bus_strb` while `bus_dir` = 0 gives exactly one `core_wr` pulse, carrying the latched address and the byte on `bus_ad_in`.
- R3: With `bus_style` = 1, `bus_ad_oe` stays low while `bus_dir` = 1 and `bus_strb` = 0. It rises after `bus_strb` rises, with `bus_ad_out` equal to the addressed location, and it falls after `bus_strb` falls.
- R4: With `bus_style` = 0, a low `bus_strb` is a read. Its falling edge gives one `core_rd` pulse, and `bus_ad_oe` is high with the addressed byte for as long as it stays low.
- R5: With `bus_style` = 0, the rising edge of `bus_dir` gives exactly one `core_wr` pulse. Its falling edge gives none.
- R6: While `bus_sel_n` is high, no `core_wr` or `core_rd` pulse occurs and `bus_ad_oe` stays low.
- R7: While `bus_lock_n` is low, all accesses are refused: no pulses and no bus drive.
- R8: A falling edge of `bus_ale` captures `bus_ad_in[6:0]` as `core_addr`. That address holds through the data phase, whatever is later placed on the bus.
- R9: `core_wr` and `core_rd` last one core cycle, never occur together, and `bus_ad_oe` is never high with `core_wr`.
- R10: A change on a bus control pin reaches `bus_ad_oe` on the third rising core clock edge after the change, and not earlier.
- R11: After reset, the outputs are low, and no pulse is generated while the synchronizers fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| bus_style | input | 1 | Static bus style: 1 strobe plus direction, 0 split read/write strobes |
| bus_strb | input | 1 | Data strobe (style 1) or active-low read strobe (style 0) |
| bus_dir | input | 1 | Direction level (style 1) or active-low write strobe (style 0) |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_lock_n | input | 1 | Active-low access lockout |
| bus_ale | input | 1 | Address-latch strobe, falling edge captures the address |
| bus_ad_in | input | 8 | Multiplexed address/data from the host |
| bus_ad_out | output | 8 | Read data toward the host |
| bus_ad_oe | output | 1 | Tristate enable for `bus_ad_out` |
| core_addr | output | 7 | Latched register/RAM address |
| core_wdata | output | 8 | Write data for the core |
| core_wr | output | 1 | Single-cycle write pulse |
| core_rd | output | 1 | Single-cycle read pulse |
| core_rdata | input | 8 | Contents of the location at `core_addr` |

## Verification
Every pin goes through two synchronizer flops and then an output register. So `bus_ad_oe`, `core_rd`, `core_wr`, `core_wdata` and the read byte move on the third core edge after the pin change. The new address appears on the third edge after `bus_ale` falls. The exact three-edge latency is checked once: the enable is sampled just after the second edge, where it must still be low, and again after the third. Every other check drives pins just after a falling clock edge and waits six edges before sampling, also just after a falling edge. Pulse counts are taken as differences of per-cycle counters across a whole bus cycle, so each write or read must add exactly one pulse cycle.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  localparam int HBI_ADDR_W      = 7;
  localparam int HBI_DATA_W      = 8;
  localparam int HBI_SYNC_STAGES = 2;

  typedef enum logic {
    STYLE_SPLIT      = 1'b0,
    STYLE_STROBE_DIR = 1'b1
  } bus_style_e;

  typedef struct packed {
    logic style;
    logic strb;
    logic dir;
    logic sel_n;
    logic lock_n;
    logic ale;
  } pins_t;

  localparam int PIN_W = $bits(pins_t);
endpackage

// File: rtl/hbi_rst_sync.sv
`timescale 1ns/1ps
module hbi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];
endmodule

// File: rtl/hbi_sync.sv
`timescale 1ns/1ps
module hbi_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbi_edge.sv
`timescale 1ns/1ps
module hbi_edge #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise[g] =  lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] &  prev_q[g];
  end
endmodule

// File: rtl/hbi_decode.sv
`timescale 1ns/1ps
module hbi_decode
  import hbi_pkg::*;
(
  input  pins_t lvl,
  input  pins_t rise,
  input  pins_t fall,
  input  logic  warm,
  output logic  wr_fire,
  output logic  rd_fire,
  output logic  rd_window,
  output logic  ale_fire
);
  logic acc_ok;
  logic wr_raw;
  logic rd_raw;
  logic win_raw;

  always_comb begin
    acc_ok = ~lvl.sel_n & lvl.lock_n & warm;
    unique case (bus_style_e'(lvl.style))
      STYLE_STROBE_DIR: begin
        wr_raw  = fall.strb & ~lvl.dir;
        rd_raw  = rise.strb &  lvl.dir;
        win_raw = lvl.strb  &  lvl.dir;
      end
      default: begin
        wr_raw  = rise.dir;
        rd_raw  = fall.strb;
        win_raw = ~lvl.strb;
      end
    endcase
    wr_fire   = acc_ok & wr_raw;
    rd_fire   = acc_ok & rd_raw  & ~wr_raw;
    rd_window = acc_ok & win_raw & ~wr_raw;
    ale_fire  = fall.ale & lvl.lock_n & warm;
  end
endmodule

// File: rtl/hbi_host_bus.sv
`timescale 1ns/1ps
module hbi_host_bus
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = HBI_ADDR_W,
  parameter int DATA_W      = HBI_DATA_W,
  parameter int SYNC_STAGES = HBI_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_style,
  input  logic              bus_strb,
  input  logic              bus_dir,
  input  logic              bus_sel_n,
  input  logic              bus_lock_n,
  input  logic              bus_ale,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  output logic              core_wr,
  output logic              core_rd,
  input  logic [DATA_W-1:0] core_rdata
);
  localparam int WARM_CYC = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_CYC + 1);

  logic  rst_sync_n;
  pins_t pins_raw, pins_lvl, pins_rise, pins_fall;
  logic  wr_fire, rd_fire, rd_window, ale_fire;

  logic [WARM_W-1:0] warm_q, warm_d;
  logic              warm;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, dout_q;
  logic              wr_q, rd_q, oe_q;
  logic              wr_d, rd_d, oe_d;

  hbi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pins_raw = '{style: bus_style, strb: bus_strb, dir: bus_dir,
                      sel_n: bus_sel_n, lock_n: bus_lock_n, ale: bus_ale};

  hbi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pins_raw),
    .q     (pins_lvl)
  );

  hbi_edge #(.W(PIN_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (pins_lvl),
    .rise  (pins_rise),
    .fall  (pins_fall)
  );

  hbi_decode u_decode (
    .lvl       (pins_lvl),
    .rise      (pins_rise),
    .fall      (pins_fall),
    .warm      (warm),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .rd_window (rd_window),
    .ale_fire  (ale_fire)
  );

  // next state
  always_comb begin
    warm   = (warm_q == WARM_W'(WARM_CYC));
    warm_d = warm ? warm_q : warm_q + WARM_W'(1);
    wr_d   = wr_fire;
    rd_d   = rd_fire;
    oe_d   = rd_window;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      warm_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      dout_q  <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      warm_q <= warm_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      if (ale_fire) addr_q  <= bus_ad_in[ADDR_W-1:0];
      if (wr_fire)  wdata_q <= bus_ad_in;
      if (rd_fire)  dout_q  <= core_rdata;
    end
  end

  assign bus_ad_out = dout_q;
  assign bus_ad_oe  = oe_q;
  assign core_addr  = addr_q;
  assign core_wdata = wdata_q;
  assign core_wr    = wr_q;
  assign core_rd    = rd_q;
endmodule

// File: rtl/hbi_host_bus_chk.sv
`timescale 1ns/1ps
module hbi_host_bus_chk #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_n,
  input logic              bus_lock_n,
  input logic              bus_ad_oe,
  input logic [DATA_W-1:0] bus_ad_out,
  input logic              core_wr,
  input logic              core_rd
);
  localparam int LIMIT = SYNC_STAGES + 3;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] sel_hi_cnt, lock_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_cnt  <= '0;
      lock_lo_cnt <= '0;
    end else begin
      if (!bus_sel_n)                      sel_hi_cnt <= '0;
      else if (sel_hi_cnt != CW'(LIMIT))   sel_hi_cnt <= sel_hi_cnt + CW'(1);
      if (bus_lock_n)                      lock_lo_cnt <= '0;
      else if (lock_lo_cnt != CW'(LIMIT))  lock_lo_cnt <= lock_lo_cnt + CW'(1);
    end
  end

  assert_sel_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi_cnt == CW'(LIMIT)) |-> (!core_wr && !core_rd && !bus_ad_oe));

  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lo_cnt == CW'(LIMIT)) |-> (!core_wr && !core_rd && !bus_ad_oe));

  assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> !core_wr);

  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd |=> !core_rd);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_wr && (core_rd || bus_ad_oe)));

  assert_dout_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ad_oe && $past(bus_ad_oe)) |-> $stable(bus_ad_out));
endmodule

bind hbi_host_bus hbi_host_bus_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel_n  (bus_sel_n),
  .bus_lock_n (bus_lock_n),
  .bus_ad_oe  (bus_ad_oe),
  .bus_ad_out (bus_ad_out),
  .core_wr    (core_wr),
  .core_rd    (core_rd)
);

// File: tb/test_hbi_host_bus.sv
`timescale 1ns/1ps
module test_hbi_host_bus;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_style, bus_strb, bus_dir, bus_sel_n, bus_lock_n, bus_ale;
  logic [7:0] bus_ad_in, bus_ad_out, core_wdata, core_rdata;
  logic       bus_ad_oe, core_wr, core_rd;
  logic [6:0] core_addr;

  int   tests = 0;
  int   fails = 0;
  int   wr_cycles = 0;
  int   rd_cycles = 0;
  logic done = 1'b0;
  logic [7:0] mem [128];

  always #2.5 clk = ~clk;

  hbi_host_bus i_hbi_host_bus (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .bus_strb(bus_strb),
    .bus_dir(bus_dir), .bus_sel_n(bus_sel_n), .bus_lock_n(bus_lock_n),
    .bus_ale(bus_ale), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_wr(core_wr), .core_rd(core_rd), .core_rdata(core_rdata)
  );

  // core storage model
  assign core_rdata = mem[core_addr];
  always @(posedge clk) begin
    if (core_wr) begin
      mem[core_addr] <= core_wdata;
      wr_cycles <= wr_cycles + 1;
    end
    if (core_rd) rd_cycles <= rd_cycles + 1;
  end

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + 90) % 256);
  endfunction
  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 91) % 256) ^ 8'hC3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic latch(input logic [7:0] a);
    bus_ad_in = a; bus_ale = 1'b1; settle();
    bus_ale = 1'b0; settle();
  endtask

  task automatic wr_cyc(input logic [7:0] a, input logic [7:0] d,
                        input logic sel, output int dw);
    int w0;
    w0 = wr_cycles;
    latch(a);
    bus_sel_n = !sel; bus_ad_in = d;
    if (bus_style) begin
      bus_dir = 1'b0; settle(); bus_strb = 1'b1; settle();
      bus_strb = 1'b0; settle(); bus_dir = 1'b1;
    end else begin
      bus_dir = 1'b0; settle(); bus_dir = 1'b1;
    end
    settle();
    bus_sel_n = 1'b1; settle();
    dw = wr_cycles - w0;
  endtask

  task automatic rd_cyc(input logic [7:0] a, input logic sel,
                        output logic [7:0] got, output logic oe_in, output int dr);
    int r0;
    r0 = rd_cycles;
    latch(a);
    bus_sel_n = !sel;
    if (bus_style) begin
      bus_dir = 1'b1; settle(); bus_strb = 1'b1; settle();
      got = bus_ad_out; oe_in = bus_ad_oe;
      bus_strb = 1'b0; settle();
    end else begin
      bus_strb = 1'b0; settle();
      got = bus_ad_out; oe_in = bus_ad_oe;
      bus_strb = 1'b1; settle();
    end
    bus_sel_n = 1'b1; settle();
    dr = rd_cycles - r0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int dw, dr;
    logic [7:0] got;
    logic oe_in;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    rst_n = 1'b0; bus_style = 1'b0; bus_strb = 1'b1; bus_dir = 1'b1;
    bus_sel_n = 1'b1; bus_lock_n = 1'b1; bus_ale = 1'b0; bus_ad_in = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R11: quiet after reset
    chk("R11 oe after reset", bus_ad_oe, 0);
    chk("R11 wr pulses after reset", wr_cycles, 0);
    chk("R11 rd pulses after reset", rd_cycles, 0);

    // R10: exact latency on the split-style read strobe
    latch(8'h03);
    bus_sel_n = 1'b0; settle();
    bus_strb = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R10 oe before third edge", bus_ad_oe, 0);
    @(posedge clk);
    #1 chk("R10 oe at third edge", bus_ad_oe, 1);
    @(negedge clk);
    bus_strb = 1'b1; settle();
    chk("R4 oe drops after read strobe", bus_ad_oe, 0);
    bus_sel_n = 1'b1; settle();

    // R5: falling edge of write strobe alone writes nothing
    latch(8'h10);
    bus_sel_n = 1'b0; bus_ad_in = 8'hEE;
    dw = wr_cycles; bus_dir = 1'b0; settle();
    chk("R5 no write on falling edge", wr_cycles - dw, 0);
    bus_dir = 1'b1; settle();
    chk("R5 write on rising edge", wr_cycles - dw, 1);
    bus_sel_n = 1'b1; settle();

    // split-style sweep, R5 writes and R4 reads
    for (int a = 0; a < 128; a++) begin
      wr_cyc(8'(a), pat_b(a), 1'b1, dw);
      chk("R5 one write pulse", dw, 1);
    end
    for (int a = 0; a < 128; a++) begin
      rd_cyc(8'(a), 1'b1, got, oe_in, dr);
      chk("R4 read data", got, pat_b(a));
      chk("R4 oe in read window", oe_in, 1);
      chk("R4 one read pulse", dr, 1);
    end

    // switch to strobe-plus-direction style
    bus_style = 1'b1; bus_strb = 1'b0; bus_dir = 1'b1; settle();
    for (int a = 0; a < 128; a++) begin
      wr_cyc(8'(a), pat_a(a), 1'b1, dw);
      chk("R2 one write pulse", dw, 1);
    end
    for (int a = 0; a < 128; a++) begin
      rd_cyc(8'(a), 1'b1, got, oe_in, dr);
      chk("R3 read data", got, pat_a(a));
      chk("R3 oe after strobe rise", oe_in, 1);
      chk("R1 read pulse with dir high", dr, 1);
    end

    // R3 and R1: window edges and no write on a read strobe
    latch(8'h21);
    bus_sel_n = 1'b0; bus_dir = 1'b1; settle();
    chk("R3 oe low before strobe rise", bus_ad_oe, 0);
    dw = wr_cycles;
    bus_strb = 1'b1; settle();
    chk("R3 oe high after strobe rise", bus_ad_oe, 1);
    chk("R3 driven byte", bus_ad_out, pat_a(33));
    bus_strb = 1'b0; settle();
    chk("R3 oe low after strobe fall", bus_ad_oe, 0);
    chk("R1 no write with dir high", wr_cycles - dw, 0);
    bus_sel_n = 1'b1; settle();

    // R8: address held despite later bus traffic
    latch(8'h05);
    bus_ad_in = 8'h7A; settle();
    chk("R8 latched address", core_addr, 5);
    wr_cyc(8'h05, 8'h3C, 1'b1, dw);
    rd_cyc(8'h05, 1'b1, got, oe_in, dr);
    chk("R8 write landed at latched address", got, 8'h3C);
    rd_cyc(8'h3C, 1'b1, got, oe_in, dr);
    chk("R8 data byte not used as address", got, pat_a(60));

    // R6: deselected accesses
    wr_cyc(8'h09, 8'h00, 1'b0, dw);
    chk("R6 no write while deselected", dw, 0);
    rd_cyc(8'h09, 1'b0, got, oe_in, dr);
    chk("R6 no drive while deselected", oe_in, 0);
    chk("R6 no read pulse while deselected", dr, 0);
    rd_cyc(8'h09, 1'b1, got, oe_in, dr);
    chk("R6 location unchanged", got, pat_a(9));

    // R7: lockout
    bus_lock_n = 1'b0; settle();
    wr_cyc(8'h0A, 8'h11, 1'b1, dw);
    chk("R7 no write under lockout", dw, 0);
    rd_cyc(8'h0A, 1'b1, got, oe_in, dr);
    chk("R7 no drive under lockout", oe_in, 0);
    chk("R7 no read pulse under lockout", dr, 0);
    bus_lock_n = 1'b1; settle();
    rd_cyc(8'h0A, 1'b1, got, oe_in, dr);
    chk("R7 location unchanged", got, pat_a(10));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule